// File: doc/BRIEF.md
# Completed-Square Cubic Evaluator

This block evaluates a fixed-point cubic polynomial. The cubic is written in vertex form around a shifted input: y = c0 + s·x·((x + h)² + g). Here h is the shift, g the offset, s the leading coefficient and c0 the constant term. Software derives these four values from the ordinary coefficients outside the block: h is the second-highest coefficient over twice the leading one, and g is the linear coefficient over the leading one minus h². The four values are written into the block through a narrow write port and stay fixed while samples stream through.

One input sample can be accepted each clock, tagged by a valid flag, and the result leaves a fixed number of cycles later with its own valid flag. The long path adds the shift, squares the sum in a dedicated unsigned squarer, adds the offset, multiplies by the product s·x, and adds the constant. The s·x product is formed in the same stage as the square. Every number is signed two's complement, W bits wide, with F fraction bits. Each product is reduced back to W bits by dropping its F lowest fraction bits, which rounds toward negative infinity. Sums wrap to W bits. No overflow is detected.

Top module: `sq_poly_eval`

## Requirements
- R1: After reset, out_valid is 0, out_y is 0 and all four coefficients are 0, so a sample sent before any write yields 0.
- R2: A sample presented with in_valid high in cycle c gives out_valid high in cycle c+5, and every accepted sample gives exactly one result. A new sample may be presented every cycle.
- R3: The result is trunc(trunc(s·x)·(trunc(t²)+g)) + c0 with t = x + h. Here trunc(p) = floor(p / 2^F), kept to W bits, and every sum wraps to W bits.
- R4: The squared term is correct for negative values of t, including the most negative W-bit value, and it is floored to W bits.
- R5: A write with cfg_we high loads cfg_data into the coefficient picked by cfg_sel: 0 is the shift h, 1 is the offset g, 2 is the scale s, 3 is the constant c0.
- R6: A coefficient write in cycle c affects only samples presented in cycle c+1 or later. Samples presented in cycle c, and samples already in the pipeline, use the old values.
- R7: While out_valid is low, out_y keeps the last result.
- R8: While cfg_we is low, cfg_sel and cfg_data have no effect on any coefficient.
- R9: Cycles with in_valid low produce no result, whatever in_x holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_sel | input | 2 | Coefficient select (0 shift, 1 offset, 2 scale, 3 constant) |
| cfg_data | input | W | Coefficient value, signed, F fraction bits |
| in_valid | input | 1 | Input sample valid |
| in_x | input | W | Input sample, signed, F fraction bits |
| out_valid | output | 1 | Result valid |
| out_y | output | W | Result, signed, F fraction bits |

## Verification
A coefficient that is stored wrongly, or read in the wrong cycle, shows up as a wrong out_y on the first sample that uses it. That is five cycles after the sample enters, and the bench hits it on purpose by sending samples in the same cycle as a write and just after it. A valid bit lost or duplicated in the pipeline shows up as a missing or extra out_valid pulse in the expected cycle. A flooring or sign fault in the squarer or a multiplier moves the result by at least one least significant bit, mostly for negative operands, which the random and corner inputs cover.

// File: rtl/sq_poly_pkg.sv
package sq_poly_pkg;
    typedef enum logic [1:0] {
        SEL_SHIFT  = 2'd0,
        SEL_OFFSET = 2'd1,
        SEL_SCALE  = 2'd2,
        SEL_CONST  = 2'd3
    } coef_sel_e;
endpackage

// File: rtl/sq_coef_bank.sv
module sq_coef_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [1:0]   sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] shift_o,
    output logic [W-1:0] offset_o,
    output logic [W-1:0] scale_o,
    output logic [W-1:0] const_o
);
    import sq_poly_pkg::*;

    typedef struct packed {
        logic [W-1:0] shift;
        logic [W-1:0] offset;
        logic [W-1:0] scale;
        logic [W-1:0] konst;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we) begin
            case (coef_sel_e'(sel))
                SEL_SHIFT:  bank_d.shift  = wdata;
                SEL_OFFSET: bank_d.offset = wdata;
                SEL_SCALE:  bank_d.scale  = wdata;
                default:    bank_d.konst  = wdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    assign shift_o  = bank_q.shift;
    assign offset_o = bank_q.offset;
    assign scale_o  = bank_q.scale;
    assign const_o  = bank_q.konst;
endmodule

// File: rtl/sq_fx_square.sv
module sq_fx_square #(
    parameter int W = 16,
    parameter int F = 8
) (
    input  logic signed [W-1:0] a,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;

    logic [W-1:0]  mag;
    logic [PW-1:0] full;

    always_comb begin
        mag  = a[W-1] ? (~a + 1'b1) : a;
        full = {{W{1'b0}}, mag} * {{W{1'b0}}, mag};
        p    = W'(full >> F);
    end
endmodule

// File: rtl/sq_fx_mul.sv
module sq_fx_mul #(
    parameter int W = 16,
    parameter int F = 8
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] p
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] ax, bx, full;

    always_comb begin
        ax   = {{W{a[W-1]}}, a};
        bx   = {{W{b[W-1]}}, b};
        full = ax * bx;
        p    = W'(full >>> F);
    end
endmodule

// File: rtl/sq_poly_eval.sv
module sq_poly_eval #(
    parameter int W = 16,
    parameter int F = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_we,
    input  logic [1:0]   cfg_sel,
    input  logic [W-1:0] cfg_data,
    input  logic         in_valid,
    input  logic [W-1:0] in_x,
    output logic         out_valid,
    output logic [W-1:0] out_y
);
    logic [W-1:0] shift_q, offset_q, scale_q, const_q;

    typedef struct packed {
        logic              v1;
        logic signed [W-1:0] t1, x1, g1, s1, c1;
        logic              v2;
        logic signed [W-1:0] sq2, sx2, g2, c2;
        logic              v3;
        logic signed [W-1:0] u3, sx3, c3;
        logic              v4;
        logic signed [W-1:0] pr4, c4;
        logic              v5;
        logic signed [W-1:0] y5;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic signed [W-1:0] sq_res, sx_res, pr_res;

    sq_coef_bank #(.W(W)) u_bank (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_data),
        .shift_o(shift_q), .offset_o(offset_q), .scale_o(scale_q), .const_o(const_q)
    );

    sq_fx_square #(.W(W), .F(F)) u_sq (.a(pipe_q.t1), .p(sq_res));
    sq_fx_mul #(.W(W), .F(F)) u_sx (.a(pipe_q.s1), .b(pipe_q.x1), .p(sx_res));
    sq_fx_mul #(.W(W), .F(F)) u_pr (.a(pipe_q.sx3), .b(pipe_q.u3), .p(pr_res));

    always_comb begin
        pipe_d = pipe_q;
        // stage 1: shift the input, capture coefficients with the sample
        pipe_d.v1  = in_valid;
        pipe_d.t1  = $signed(in_x) + $signed(shift_q);
        pipe_d.x1  = $signed(in_x);
        pipe_d.g1  = $signed(offset_q);
        pipe_d.s1  = $signed(scale_q);
        pipe_d.c1  = $signed(const_q);
        // stage 2: square and scale product side by side
        pipe_d.v2  = pipe_q.v1;
        pipe_d.sq2 = sq_res;
        pipe_d.sx2 = sx_res;
        pipe_d.g2  = pipe_q.g1;
        pipe_d.c2  = pipe_q.c1;
        // stage 3: add the offset
        pipe_d.v3  = pipe_q.v2;
        pipe_d.u3  = pipe_q.sq2 + pipe_q.g2;
        pipe_d.sx3 = pipe_q.sx2;
        pipe_d.c3  = pipe_q.c2;
        // stage 4: multiply by the scale product
        pipe_d.v4  = pipe_q.v3;
        pipe_d.pr4 = pr_res;
        pipe_d.c4  = pipe_q.c3;
        // stage 5: add the constant, hold the result between samples
        pipe_d.v5  = pipe_q.v4;
        if (pipe_q.v4) pipe_d.y5 = pipe_q.pr4 + pipe_q.c4;
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.v5;
    assign out_y     = pipe_q.y5;
endmodule

// File: rtl/sq_poly_eval_chk.sv
module sq_poly_eval_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         cfg_we,
    input logic [1:0]   cfg_sel,
    input logic [W-1:0] cfg_data,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_y,
    input logic [W-1:0] shift_q,
    input logic [W-1:0] offset_q,
    input logic [W-1:0] scale_q,
    input logic [W-1:0] const_q
);
    logic [2:0] since_rst;
    logic       was_rst;

    always_ff @(posedge clk) begin
        was_rst <= rst;
        if (rst)                  since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R1
    always @(posedge clk) begin
        if (was_rst === 1'b1 && rst === 1'b0)
            reset_state_chk: assert (!out_valid && out_y == '0 && shift_q == '0 &&
                                     offset_q == '0 && scale_q == '0 && const_q == '0)
                else $error("reset state wrong");
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 3'd5) |-> !out_valid);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd1 && !out_valid) |-> $stable(out_y));

    // R5
    scale_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd2) |=> (scale_q == $past(cfg_data)));

    // R5
    shift_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == 2'd0) |=> (shift_q == $past(cfg_data)));

    // R8
    idle_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(shift_q) && $stable(offset_q) && $stable(scale_q) && $stable(const_q)));
endmodule

bind sq_poly_eval sq_poly_eval_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_valid(in_valid), .out_valid(out_valid), .out_y(out_y),
    .shift_q(shift_q), .offset_q(offset_q), .scale_q(scale_q), .const_q(const_q)
);

// File: tb/sq_poly_eval_test.sv
module sq_poly_eval_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int F = 8;
    localparam int LAT = 5;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_sel = '0;
    logic [W-1:0] cfg_data = '0;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_x = '0;
    logic         out_valid;
    logic [W-1:0] out_y;

    sq_poly_eval #(.W(W), .F(F)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_x(in_x), .out_valid(out_valid), .out_y(out_y)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic signed [W-1:0] ch = '0, cg = '0, cs = '0, cc = '0;
    logic signed [W-1:0] last_y = '0;
    logic signed [W-1:0] exp_q[$];
    int                  due_q[$];
    string               tag_q[$];

    function automatic longint wr(input longint v);
        logic signed [W-1:0] r;
        r = v[W-1:0];
        return longint'(r);
    endfunction

    function automatic logic signed [W-1:0] model(input logic signed [W-1:0] x,
        input logic signed [W-1:0] h, input logic signed [W-1:0] g,
        input logic signed [W-1:0] s, input logic signed [W-1:0] c);
        longint t, sq, sx, u, pr;
        t  = wr(longint'(x) + longint'(h));
        sq = wr((t * t) >>> F);
        sx = wr((longint'(s) * longint'(x)) >>> F);
        u  = wr(sq + longint'(g));
        pr = wr((sx * u) >>> F);
        return W'(wr(pr + longint'(c)));
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one cycle: compare outputs of this cycle, then drive inputs for it
    task automatic step(input logic vin, input logic signed [W-1:0] x,
                        input logic we, input logic [1:0] sel, input logic signed [W-1:0] data,
                        input string tag);
        @(negedge clk);
        cyc++;
        if (out_valid) begin
            if (due_q.size() == 0 || due_q[0] != cyc) begin
                chk(1'b0, "R9 unexpected out_valid", 1, 0);
            end else begin
                chk($signed(out_y) == exp_q[0], tag_q[0], longint'($signed(out_y)), longint'(exp_q[0]));
                last_y = exp_q[0];
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
        end else begin
            if (due_q.size() != 0 && due_q[0] == cyc) begin
                chk(1'b0, "R2 missing out_valid", 0, 1);
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
            chk($signed(out_y) == last_y, "R7 hold while idle", longint'($signed(out_y)), longint'(last_y));
        end
        in_valid = vin; in_x = x; cfg_we = we; cfg_sel = sel; cfg_data = data;
        if (vin) begin
            exp_q.push_back(model(x, ch, cg, cs, cc));
            due_q.push_back(cyc + LAT);
            tag_q.push_back(tag);
        end
        if (we) begin
            case (sel)
                2'd0: ch = data;
                2'd1: cg = data;
                2'd2: cs = data;
                default: cc = data;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'sh5a5a, 1'b0, 2'd0, 16'sd0, "");
    endtask

    task automatic wr_coef(input logic [1:0] sel, input logic signed [W-1:0] v);
        step(1'b0, '0, 1'b1, sel, v, "");
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
        chk(out_y == '0, "R1 out_y after reset", longint'($signed(out_y)), 0);
        // R1: zero coefficients give zero
        step(1'b1, 16'sd384, 1'b0, 2'd0, '0, "R1 zero coefficients");
        idle(6);

        // R5: load each coefficient (h=0.5, g=-0.25, s=1.5, c=0.75)
        wr_coef(2'd0, 16'sd128);
        wr_coef(2'd1, -16'sd64);
        wr_coef(2'd2, 16'sd384);
        wr_coef(2'd3, 16'sd192);
        step(1'b1, 16'sd256, 1'b0, 2'd0, '0, "R5 R3 directed x=1");
        step(1'b1, 16'sd0,   1'b0, 2'd0, '0, "R3 directed x=0");
        step(1'b1, -16'sd128, 1'b0, 2'd0, '0, "R3 directed t=0");
        step(1'b1, -16'sd333, 1'b0, 2'd0, '0, "R4 negative t");
        step(1'b1, 16'sd1,   1'b0, 2'd0, '0, "R3 smallest step");
        idle(6);

        // R4: most negative t (shift 0, x = most negative, scale 0)
        wr_coef(2'd0, 16'sd0);
        wr_coef(2'd2, 16'sd0);
        step(1'b1, 16'sh8000, 1'b0, 2'd0, '0, "R4 most negative t");
        idle(6);
        // square result seen through scale 1.0
        wr_coef(2'd2, 16'sd256);
        wr_coef(2'd1, 16'sd0);
        wr_coef(2'd3, 16'sd0);
        step(1'b1, -16'sd5, 1'b0, 2'd0, '0, "R4 floor of tiny negative square");
        step(1'b1, -16'sd300, 1'b0, 2'd0, '0, "R4 negative t square");
        idle(6);

        // R8: cfg_data/cfg_sel toggle without write enable
        step(1'b0, '0, 1'b0, 2'd2, 16'sh7f00, "");
        step(1'b0, '0, 1'b0, 2'd3, -16'sd900, "");
        step(1'b1, 16'sd200, 1'b0, 2'd1, 16'sd1000, "R8 ignored cfg without we");
        idle(6);

        // R6: write in same cycle as sample, and while samples are in flight
        step(1'b1, 16'sd100, 1'b0, 2'd0, '0, "R6 in flight before write");
        step(1'b1, 16'sd150, 1'b1, 2'd3, 16'sd300, "R6 same cycle as write");
        step(1'b1, 16'sd150, 1'b1, 2'd2, -16'sd200, "R6 after const write");
        step(1'b1, 16'sd150, 1'b1, 2'd0, -16'sd50, "R6 after scale write");
        step(1'b1, 16'sd150, 1'b0, 2'd0, '0, "R6 after shift write");
        idle(6);

        // R9: no result for invalid cycles with busy in_x
        for (int i = 0; i < 8; i++) step(1'b0, W'($urandom_range(0, 65535)), 1'b0, 2'd0, '0, "");
        // R2: back-to-back stream
        for (int i = 0; i < 12; i++)
            step(1'b1, W'(i * 40 - 240), 1'b0, 2'd0, '0, "R2 back-to-back");
        idle(6);

        // random stream with occasional writes
        for (int i = 0; i < 400; i++) begin
            logic v, we;
            logic [1:0] sel;
            logic signed [W-1:0] x, d;
            v   = ($urandom_range(0, 3) != 0);
            we  = ($urandom_range(0, 9) == 0);
            sel = 2'($urandom_range(0, 3));
            x   = W'(int'($urandom_range(0, 1023)) - 512);
            d   = (sel < 2'd2) ? W'(int'($urandom_range(0, 511)) - 256)
                               : W'(int'($urandom_range(0, 1023)) - 512);
            step(v, x, we, sel, d, "R3 R6 random");
        end
        idle(8);
        chk(due_q.size() == 0, "R2 all results returned", due_q.size(), 0);
        finish_run();
    end
endmodule